// File: doc/BRIEF.md
# Doorbell Scatter Buffer Queue

This block lets a small, fixed window of bus address space stand in for a long run of large memory buffers. Local software loads buffer base addresses, each on a 4 KiB boundary, into an internal queue. Every bus access whose address lands inside the window is translated into the buffer at the head of the queue: the translated address is that buffer's base plus the access's distance from the window base, so any offset below 4 KiB travels in the low address bits.

The remote side advances through the pool by writing a doorbell. Each doorbell retires the head buffer and reports its address on a retired-buffer output. The next queued buffer then becomes current. A window of a few pages can therefore cover as many buffers as software keeps supplying. Data movement and page translation stay outside this block.

A two-state controller tracks whether a buffer is current. In state `Q_EMPTY` the queue holds nothing; an accepted push takes it to `Q_LIVE`. In `Q_LIVE` at least one buffer is queued; a doorbell that removes the last buffer, with no push accepted in the same cycle, returns it to `Q_EMPTY`. Every other event keeps the current state.

Top module: `doorbell_scatter_queue`

## Requirements
- R1: Out of reset, push_ready is 1 and xl_valid, ret_valid, err_underflow and err_misalign are all 0.
- R2: A push whose address has any of bits [11:0] set is never stored, and it sets err_misalign, which stays at 1 until reset. A push with bits [11:0] all zero is stored when push_ready is 1.
- R3: The queue holds at most DEPTH (default 16) buffers, counting the current one. When it is full, push_ready is 0 and a push is neither stored nor flagged.
- R4: An access with WIN_BASE <= acc_addr < WIN_BASE + WIN_SIZE, made while a buffer is current, raises xl_valid for one cycle on the next cycle. xl_addr is then the current base plus (acc_addr - WIN_BASE).
- R5: An access outside the window produces no translated output and sets no error.
- R6: A doorbell while a buffer is current raises ret_valid for exactly one cycle on the next cycle, with ret_addr equal to the retired base. Buffers are retired in the order they were pushed, and later accesses use the next buffer.
- R7: A doorbell and an in-window access in the same cycle translate the access with the buffer being retired. The swap to the next buffer happens after that.
- R8: An in-window access or a doorbell while no buffer is queued produces neither xl_valid nor ret_valid. It sets err_underflow, which stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Offer a buffer base address |
| push_addr | input | AW | Buffer base address to enqueue |
| push_ready | output | 1 | Queue has room for a push |
| acc_valid | input | 1 | A bus access is presented |
| acc_addr | input | BW | Bus address of the access |
| xl_valid | output | 1 | Translated address valid (one cycle) |
| xl_addr | output | AW | Translated memory address |
| db_write | input | 1 | Remote doorbell write |
| ret_valid | output | 1 | Retired buffer reported (one cycle) |
| ret_addr | output | AW | Base of the retired buffer |
| err_underflow | output | 1 | Sticky: access or doorbell with an empty queue |
| err_misalign | output | 1 | Sticky: push of a base not on a 4 KiB boundary |

## Verification
The hardest condition to reach is a completely full queue with the refused push still observable. The stimulus fills all sixteen slots with distinct aligned bases and offers one more base while push_ready is low. It then drains the queue with sixteen doorbells and compares every retired address against the push order, so that a stored seventeenth entry, or a lost one, shows up at the retired-buffer output. The same-cycle doorbell and access case is driven directly, and both the translated and the retired address are checked against the outgoing buffer.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
    localparam int PAGE_BITS = 12;

    typedef enum logic [0:0] {
        Q_EMPTY = 1'b0,
        Q_LIVE  = 1'b1
    } q_state_e;
endpackage

// File: rtl/dsq_fifo.sv
module dsq_fifo #(
    parameter int DEPTH = 16,
    parameter int AW    = 48,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_data,
    input  logic             rd_en,
    output logic [AW-1:0]    head,
    output logic [CNT_W-1:0] count
);
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [AW-1:0]    slot [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_ptr == PTR_W'(i)) begin
                slot[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = slot[rd_ptr];
endmodule

// File: rtl/dsq_xlate.sv
module dsq_xlate #(
    parameter int            BW       = 32,
    parameter int            AW       = 48,
    parameter logic [BW-1:0] WIN_BASE = 32'h8000_0000,
    parameter logic [BW-1:0] WIN_SIZE = 32'h0000_4000
) (
    input  logic          acc_valid,
    input  logic [BW-1:0] acc_addr,
    input  logic [AW-1:0] base,
    output logic          hit,
    output logic [AW-1:0] xl
);
    logic [BW-1:0] offset;

    always_comb begin
        offset = acc_addr - WIN_BASE;
        hit    = acc_valid && (acc_addr >= WIN_BASE) && (offset < WIN_SIZE);
        xl     = base + AW'(offset);
    end
endmodule

// File: rtl/dsq_ctrl.sv
module dsq_ctrl
    import dsq_pkg::*;
#(
    parameter int  DEPTH = 16,
    parameter int  AW    = 48,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic             push_aligned,
    input  logic             db_write,
    input  logic             acc_hit,
    input  logic [AW-1:0]    acc_xl,
    input  logic [AW-1:0]    head,
    input  logic [CNT_W-1:0] count,
    output logic             push_ok,
    output logic             pop,
    output logic             push_ready,
    output logic             xl_valid,
    output logic [AW-1:0]    xl_addr,
    output logic             ret_valid,
    output logic [AW-1:0]    ret_addr,
    output logic             err_underflow,
    output logic             err_misalign,
    output q_state_e         state
);
    q_state_e state_d;
    logic     live, under_ev, misal_ev;

    always_comb begin
        live       = (state == Q_LIVE);
        push_ready = (count != CNT_W'(DEPTH));
        push_ok    = push_valid && push_aligned && push_ready;
        misal_ev   = push_valid && !push_aligned && push_ready;
        pop        = db_write && live;
        under_ev   = !live && (db_write || acc_hit);
        state_d    = state;
        unique case (state)
            Q_EMPTY: if (push_ok) state_d = Q_LIVE;
            Q_LIVE:  if (pop && !push_ok && count == CNT_W'(1)) state_d = Q_EMPTY;
            default: state_d = Q_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_valid      <= 1'b0;
            xl_addr       <= '0;
            ret_valid     <= 1'b0;
            ret_addr      <= '0;
            err_underflow <= 1'b0;
            err_misalign  <= 1'b0;
        end else begin
            xl_valid  <= acc_hit && live;
            ret_valid <= pop;
            if (acc_hit && live) xl_addr  <= acc_xl;
            if (pop)             ret_addr <= head;
            if (under_ev) err_underflow <= 1'b1;
            if (misal_ev) err_misalign  <= 1'b1;
        end
    end
endmodule

// File: rtl/doorbell_scatter_queue.sv
module doorbell_scatter_queue
    import dsq_pkg::*;
#(
    parameter int            DEPTH    = 16,
    parameter int            AW       = 48,
    parameter int            BW       = 32,
    parameter logic [BW-1:0] WIN_BASE = 32'h8000_0000,
    parameter logic [BW-1:0] WIN_SIZE = 32'h0000_4000,
    localparam int           CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [AW-1:0] push_addr,
    output logic          push_ready,
    input  logic          acc_valid,
    input  logic [BW-1:0] acc_addr,
    output logic          xl_valid,
    output logic [AW-1:0] xl_addr,
    input  logic          db_write,
    output logic          ret_valid,
    output logic [AW-1:0] ret_addr,
    output logic          err_underflow,
    output logic          err_misalign
);
    logic             push_ok, pop, acc_hit, push_aligned;
    logic [AW-1:0]    head, acc_xl;
    logic [CNT_W-1:0] q_count;
    q_state_e         q_state;

    assign push_aligned = (push_addr[PAGE_BITS-1:0] == '0);

    dsq_fifo #(.DEPTH(DEPTH), .AW(AW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(push_ok), .wr_data(push_addr),
        .rd_en(pop), .head(head), .count(q_count)
    );

    dsq_xlate #(.BW(BW), .AW(AW), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_xlate (
        .acc_valid(acc_valid), .acc_addr(acc_addr), .base(head),
        .hit(acc_hit), .xl(acc_xl)
    );

    dsq_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid),
        .push_aligned(push_aligned), .db_write(db_write), .acc_hit(acc_hit),
        .acc_xl(acc_xl), .head(head), .count(q_count), .push_ok(push_ok),
        .pop(pop), .push_ready(push_ready), .xl_valid(xl_valid),
        .xl_addr(xl_addr), .ret_valid(ret_valid), .ret_addr(ret_addr),
        .err_underflow(err_underflow), .err_misalign(err_misalign),
        .state(q_state)
    );
endmodule

// File: rtl/dsq_checker.sv
module dsq_checker
    import dsq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             push_ready,
    input logic             acc_valid,
    input logic             db_write,
    input logic             xl_valid,
    input logic             ret_valid,
    input logic             err_underflow,
    input logic             err_misalign,
    input logic [CNT_W-1:0] cnt,
    input q_state_e         state
);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    a_r3_refused_push: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_ready && !db_write) |=> (cnt == $past(cnt)));

    a_r2_misalign_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_misalign |=> err_misalign);

    a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> err_underflow);

    a_r4_xl_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
        xl_valid |-> $past(acc_valid));

    a_r6_ret_needs_doorbell: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $past(db_write));

    a_r8_empty_no_xl: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && state == Q_EMPTY) |=> !xl_valid);

    a_r6_state_tracks_queue: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_LIVE) == (cnt != '0));
endmodule

bind doorbell_scatter_queue dsq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_ready(push_ready),
    .acc_valid(acc_valid), .db_write(db_write), .xl_valid(xl_valid),
    .ret_valid(ret_valid), .err_underflow(err_underflow),
    .err_misalign(err_misalign), .cnt(q_count), .state(q_state)
);

// File: tb/doorbell_scatter_queue_bench.sv
module doorbell_scatter_queue_bench;
    localparam int            AW    = 48;
    localparam int            BW    = 32;
    localparam int            DEPTH = 16;
    localparam logic [BW-1:0] WB    = 32'h8000_0000;
    localparam logic [BW-1:0] WS    = 32'h0000_4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_valid = 1'b0;
    logic [AW-1:0] push_addr = '0;
    logic          push_ready;
    logic          acc_valid = 1'b0;
    logic [BW-1:0] acc_addr = '0;
    logic          xl_valid;
    logic [AW-1:0] xl_addr;
    logic          db_write = 1'b0;
    logic          ret_valid;
    logic [AW-1:0] ret_addr;
    logic          err_underflow, err_misalign;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    doorbell_scatter_queue #(.DEPTH(DEPTH), .AW(AW), .BW(BW),
        .WIN_BASE(WB), .WIN_SIZE(WS)) u_doorbell_scatter_queue (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid),
        .push_addr(push_addr), .push_ready(push_ready), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .xl_valid(xl_valid), .xl_addr(xl_addr),
        .db_write(db_write), .ret_valid(ret_valid), .ret_addr(ret_addr),
        .err_underflow(err_underflow), .err_misalign(err_misalign)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge; outputs are sampled at the next falling edge.
    task automatic cycle(input bit pv, input logic [AW-1:0] pa, input bit av,
                         input logic [BW-1:0] aa, input bit db);
        push_valid = pv; push_addr = pa; acc_valid = av; acc_addr = aa; db_write = db;
        @(negedge clk);
        push_valid = 0; acc_valid = 0; db_write = 0;
    endtask

    task automatic t_reset;
        chk("R1 push_ready", 64'(push_ready), 64'd1);
        chk("R1 xl_valid", 64'(xl_valid), 64'd0);
        chk("R1 ret_valid", 64'(ret_valid), 64'd0);
        chk("R1 err_underflow", 64'(err_underflow), 64'd0);
        chk("R1 err_misalign", 64'(err_misalign), 64'd0);
    endtask

    task automatic t_underflow;
        cycle(0, '0, 1, WB + 32'h20, 0);
        chk("R8 no xl when empty", 64'(xl_valid), 64'd0);
        chk("R8 underflow on access", 64'(err_underflow), 64'd1);
        cycle(0, '0, 0, '0, 1);
        chk("R8 no ret when empty", 64'(ret_valid), 64'd0);
        chk("R8 underflow sticky", 64'(err_underflow), 64'd1);
    endtask

    task automatic t_misalign;
        cycle(1, 48'h12_3456_7123, 0, '0, 0);
        chk("R2 misalign flagged", 64'(err_misalign), 64'd1);
        cycle(1, 48'h10_0000_0000, 0, '0, 0);
        cycle(0, '0, 1, WB + 32'h10, 0);
        chk("R2 misaligned not stored xl_valid", 64'(xl_valid), 64'd1);
        chk("R2 R4 head is aligned push", 64'(xl_addr), 64'h10_0000_0010);
        chk("R2 misalign sticky", 64'(err_misalign), 64'd1);
    endtask

    task automatic t_window;
        cycle(0, '0, 1, WB - 32'h1, 0);
        chk("R5 below window", 64'(xl_valid), 64'd0);
        cycle(0, '0, 1, WB + WS, 0);
        chk("R5 above window", 64'(xl_valid), 64'd0);
        cycle(0, '0, 1, WB + WS - 32'h1, 0);
        chk("R4 top of window valid", 64'(xl_valid), 64'd1);
        chk("R4 top of window addr", 64'(xl_addr), 64'h10_0000_3FFF);
        cycle(0, '0, 0, '0, 0);
        chk("R4 xl one cycle", 64'(xl_valid), 64'd0);
    endtask

    task automatic t_order;
        cycle(1, 48'h20_0000_0000, 0, '0, 0);
        cycle(1, 48'h30_0000_5000, 0, '0, 0);
        cycle(0, '0, 0, '0, 1);
        chk("R6 ret_valid", 64'(ret_valid), 64'd1);
        chk("R6 ret_addr first", 64'(ret_addr), 64'h10_0000_0000);
        cycle(0, '0, 1, WB + 32'h0ABC, 0);
        chk("R6 ret one cycle", 64'(ret_valid), 64'd0);
        chk("R6 next buffer used", 64'(xl_addr), 64'h20_0000_0ABC);
    endtask

    task automatic t_same_cycle;
        cycle(0, '0, 1, WB + 32'h1004, 1);
        chk("R7 xl_valid", 64'(xl_valid), 64'd1);
        chk("R7 old buffer used", 64'(xl_addr), 64'h20_0000_1004);
        chk("R7 retired old", 64'(ret_addr), 64'h20_0000_0000);
        cycle(0, '0, 1, WB + 32'h8, 0);
        chk("R7 swap after", 64'(xl_addr), 64'h30_0000_5008);
        cycle(0, '0, 0, '0, 1);
        chk("R6 last retired", 64'(ret_addr), 64'h30_0000_5000);
    endtask

    task automatic t_full;
        for (int i = 0; i < DEPTH; i++) begin
            cycle(1, 48'h40_0000_0000 + AW'(i) * 48'h1000, 0, '0, 0);
        end
        chk("R3 ready low when full", 64'(push_ready), 64'd0);
        cycle(1, 48'h77_7777_7000, 0, '0, 0);
        chk("R3 refused push no misalign", 64'(err_misalign), 64'd1);
        chk("R3 still full", 64'(push_ready), 64'd0);
        for (int i = 0; i < DEPTH; i++) begin
            cycle(0, '0, 0, '0, 1);
            chk("R3 R6 drain order", 64'(ret_addr), 64'(48'h40_0000_0000 + AW'(i) * 48'h1000));
            chk("R3 drain valid", 64'(ret_valid), 64'd1);
        end
        chk("R3 ready after drain", 64'(push_ready), 64'd1);
        cycle(0, '0, 0, '0, 1);
        chk("R3 extra push not stored", 64'(ret_valid), 64'd0);
        cycle(0, '0, 1, WB, 0);
        chk("R8 empty again no xl", 64'(xl_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_underflow();
        t_misalign();
        t_window();
        t_order();
        t_same_cycle();
        t_full();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule